// File: doc/BRIEF.md
# Halfword Pack and Byte Select Unit

This unit is a 32-bit datapath slice that builds a result word out of two source operands. In the two pack modes it keeps one halfword of operand A and takes the other halfword from operand B after a shift. In the bottom-top variant, B is shifted left logically. In the top-bottom variant, B is shifted right arithmetically. In select mode it builds each result byte from either A or B, as chosen by one bit of an external 4-bit greater-or-equal flag vector.

The operation is computed combinationally and then captured in output registers. Each accepted input produces one registered result, together with a valid strobe, on the following clock. A shift amount outside the range allowed for the chosen pack mode, or an undefined operation code, gives a zero result and raises an error flag. Decoding, flag generation and operand fetch are done by the surrounding pipeline.

Top module: `hps_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `res`, `res_valid` and `res_err` are cleared to zero on that edge.
- R2: `res_valid` is high exactly one clock after a cycle with `in_valid` high, and `res`/`res_err` update on that edge. After a cycle with `in_valid` low, `res_valid` is low and `res` keeps its previous value.
- R3: For `op` = 3'b000 (pack bottom-top), `res[15:0]` equals `op_a[15:0]`.
- R4: For `op` = 3'b000 with `shamt` from 0 to 31, `res[31:16]` equals bits 31:16 of `op_b` logically shifted left by `shamt`.
- R5: For `op` = 3'b001 (pack top-bottom), `res[31:16]` equals `op_a[31:16]`.
- R6: For `op` = 3'b001 with `shamt` from 1 to 32, `res[15:0]` equals bits 15:0 of `op_b` arithmetically shifted right by `shamt`. With a shift of 32, every bit of this half is a copy of `op_b[31]`.
- R7: For `op` = 3'b010 (byte select), result byte k (bits 8k+7:8k) equals byte k of `op_a` when `ge_flags[k]` is 1, and byte k of `op_b` when it is 0, for k = 0..3.
- R8: An out-of-range `shamt` gives `res` = 0 and `res_err` = 1. For `op` = 3'b000 this means `shamt` > 31. For `op` = 3'b001 it means `shamt` = 0 or `shamt` > 32. Results with an in-range shift have `res_err` = 0.
- R9: In byte select mode `shamt` has no effect: the result and `res_err` = 0 are the same for every `shamt` value.
- R10: Operation codes 3'b011 to 3'b111 produce `res` = 0 and `res_err` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and operation are present this cycle |
| op | input | 3 | Operation: 000 pack bottom-top, 001 pack top-bottom, 010 byte select |
| op_a | input | 32 | First source operand |
| op_b | input | 32 | Second source operand, shifted in pack modes |
| shamt | input | 6 | Shift amount for the pack modes |
| ge_flags | input | 4 | Per-byte select flags, bit k for byte k |
| res | output | 32 | Registered result |
| res_valid | output | 1 | Result is valid this cycle |
| res_err | output | 1 | Shift amount out of range or undefined operation |

## Verification
The bench targets the edges of the shift windows.

- **Left pack, shifts of 0 and 31.** A design that used a 5-bit shift count would wrap 32 and above instead of flagging them.
- **Right pack, shifts of 1, 31 and 32.** A design that got the shift-32 case wrong would leave stale bits in the low half. A design that used a logical shift would fill that half with zeros on a negative B instead of sign copies.
- **Shift amount 0 in the right pack.** This must raise the error; a design that forgot the lower bound would return B's low half unshifted.
- **Select mode.** The bench sends flag patterns that are all-ones, all-zeros and alternating, which catch swapped lanes or an inverted flag sense. It also sends junk shift amounts to show the shift has no effect there.
- **Idle cycles.** These expose a result register that reloads without a valid input.

// File: rtl/hps_pkg.sv
package hps_pkg;
  typedef enum logic [2:0] {
    OP_PACK_BT = 3'd0,
    OP_PACK_TB = 3'd1,
    OP_BSEL    = 3'd2
  } hps_op_e;
endpackage

// File: rtl/hps_pack.sv
module hps_pack #(
  parameter int DATA_W = 32,
  parameter int SH_W   = 6
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [SH_W-1:0]   shamt,
  output logic [DATA_W-1:0] bt_res,
  output logic [DATA_W-1:0] tb_res,
  output logic              bt_ok,
  output logic              tb_ok
);
  localparam int HALF = DATA_W / 2;
  localparam logic [SH_W-1:0] BT_MAX = SH_W'(DATA_W - 1);
  localparam logic [SH_W-1:0] TB_MAX = SH_W'(DATA_W);

  logic [DATA_W-1:0] lsl_b;
  logic [DATA_W-1:0] asr_b;

  always_comb begin
    lsl_b  = op_b << shamt;
    asr_b  = DATA_W'($signed(op_b) >>> shamt);
    bt_res = {lsl_b[DATA_W-1:HALF], op_a[HALF-1:0]};
    tb_res = {op_a[DATA_W-1:HALF], asr_b[HALF-1:0]};
    bt_ok  = (shamt <= BT_MAX);
    tb_ok  = (shamt != '0) && (shamt <= TB_MAX);
  end
endmodule

// File: rtl/hps_bytesel.sv
module hps_bytesel #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]   op_a,
  input  logic [DATA_W-1:0]   op_b,
  input  logic [DATA_W/8-1:0] ge_flags,
  output logic [DATA_W-1:0]   sel_res
);
  localparam int LANES = DATA_W / 8;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign sel_res[8*k +: 8] = ge_flags[k] ? op_a[8*k +: 8] : op_b[8*k +: 8];
  end
endmodule

// File: rtl/hps_unit.sv
module hps_unit
  import hps_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SH_W   = 6,
  localparam int LANES = DATA_W / 8,
  localparam int HALF  = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [SH_W-1:0]   shamt,
  input  logic [LANES-1:0]  ge_flags,
  output logic [DATA_W-1:0] res,
  output logic              res_valid,
  output logic              res_err
);
  logic [DATA_W-1:0] bt_res, tb_res, sel_res, nxt_res;
  logic              bt_ok, tb_ok, nxt_err;

  hps_pack #(.DATA_W(DATA_W), .SH_W(SH_W)) u_pack (
    .op_a(op_a), .op_b(op_b), .shamt(shamt),
    .bt_res(bt_res), .tb_res(tb_res), .bt_ok(bt_ok), .tb_ok(tb_ok)
  );

  hps_bytesel #(.DATA_W(DATA_W)) u_sel (
    .op_a(op_a), .op_b(op_b), .ge_flags(ge_flags), .sel_res(sel_res)
  );

  always_comb begin
    nxt_res = '0;
    nxt_err = 1'b1;
    case (op)
      OP_PACK_BT: begin nxt_err = !bt_ok; nxt_res = bt_ok ? bt_res : '0; end
      OP_PACK_TB: begin nxt_err = !tb_ok; nxt_res = tb_ok ? tb_res : '0; end
      OP_BSEL:    begin nxt_err = 1'b0;   nxt_res = sel_res;             end
      default:    begin nxt_err = 1'b1;   nxt_res = '0;                  end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res       <= '0;
      res_valid <= 1'b0;
      res_err   <= 1'b0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) begin
        res     <= nxt_res;
        res_err <= nxt_err;
      end
    end
  end

  // R2: strobe follows the input one cycle later, result held when idle
  p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!res_valid && $stable(res)));
  // R3: low half of a left pack comes straight from A
  p_bt_low_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_PACK_BT && shamt < SH_W'(DATA_W))
      |=> res[HALF-1:0] == $past(op_a[HALF-1:0]));
  // R5: high half of a right pack comes straight from A
  p_tb_high_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_PACK_TB && shamt != '0 && shamt <= SH_W'(DATA_W))
      |=> res[DATA_W-1:HALF] == $past(op_a[DATA_W-1:HALF]));
  // R7: lowest byte of a select follows flag bit 0
  p_sel_lane0_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_BSEL)
      |=> res[7:0] == ($past(ge_flags[0]) ? $past(op_a[7:0]) : $past(op_b[7:0])));
  // R8: zero shift on a right pack is an error
  p_tb_zero_err_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_PACK_TB && shamt == '0) |=> (res_err && res == '0));
  // R8/R10: any flagged error carries a zero result
  p_err_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_err) |-> res == '0);
endmodule

// File: tb/sim_hps_unit.sv
module sim_hps_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [2:0]  op;
  logic [31:0] op_a, op_b;
  logic [5:0]  shamt;
  logic [3:0]  ge_flags;
  logic [31:0] res;
  logic        res_valid, res_err;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  hps_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .op_a(op_a),
    .op_b(op_b), .shamt(shamt), .ge_flags(ge_flags),
    .res(res), .res_valid(res_valid), .res_err(res_err)
  );

  function automatic logic model_err(input logic [2:0] o, input logic [5:0] s);
    case (o)
      3'd0:    return s > 6'd31;
      3'd1:    return (s == 6'd0) || (s > 6'd32);
      3'd2:    return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [31:0] model_res(input logic [2:0] o, input logic [31:0] a,
      input logic [31:0] b, input logic [5:0] s, input logic [3:0] g);
    logic [31:0] r;
    logic [63:0] ext;
    r = '0;
    if (model_err(o, s)) return 32'h0;
    case (o)
      3'd0: begin
        r[15:0] = a[15:0];
        for (int i = 16; i < 32; i++) r[i] = (i >= s) ? b[i - s] : 1'b0;
      end
      3'd1: begin
        r[31:16] = a[31:16];
        ext = {{32{b[31]}}, b};
        for (int i = 0; i < 16; i++) r[i] = ext[i + s];
      end
      default: begin
        for (int k = 0; k < 4; k++) r[8*k +: 8] = g[k] ? a[8*k +: 8] : b[8*k +: 8];
      end
    endcase
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic string res_tag(input logic [2:0] o, input logic [5:0] s);
    if (model_err(o, s)) return (o > 3'd2) ? "R10" : "R8";
    case (o)
      3'd0: return "R3/R4";
      3'd1: return (s == 6'd32) ? "R5/R6 shift32" : "R5/R6";
      default: return "R7";
    endcase
  endfunction

  task automatic run_op(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
      input logic [5:0] s, input logic [3:0] g);
    @(negedge clk);
    in_valid = 1'b1; op = o; op_a = a; op_b = b; shamt = s; ge_flags = g;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 valid", {31'd0, res_valid}, 32'd1);
    check(res_tag(o, s), res, model_res(o, a, b, s, g));
    check((o > 3'd2) ? "R10 err" : (o == 3'd2) ? "R9 err" : "R8 err",
          {31'd0, res_err}, {31'd0, model_err(o, s)});
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] hold;
    logic [31:0] sel_ref;
    process::self().srandom(32'd1234);
    rst = 1'b1; in_valid = 1'b1; op = 3'd2; op_a = '1; op_b = '1; shamt = '0; ge_flags = '1;
    repeat (3) @(negedge clk);
    check("R1 res", res, 32'h0);
    check("R1 valid", {31'd0, res_valid}, 32'd0);
    check("R1 err", {31'd0, res_err}, 32'd0);
    rst = 1'b0; in_valid = 1'b0;

    // R4 / R3 left-pack window edges
    run_op(3'd0, 32'h1234_5678, 32'h0000_ABCD, 6'd0, 4'h0);
    run_op(3'd0, 32'h1234_5678, 32'h0000_0001, 6'd31, 4'h0);
    run_op(3'd0, 32'h1234_5678, 32'hFFFF_FFFF, 6'd32, 4'h0);   // R8
    run_op(3'd0, 32'h1234_5678, 32'hFFFF_FFFF, 6'd63, 4'h0);   // R8
    // R6 / R5 right-pack window edges
    run_op(3'd1, 32'hCAFE_0000, 32'h8001_0000, 6'd1, 4'h0);
    run_op(3'd1, 32'hCAFE_0000, 32'h8000_0000, 6'd31, 4'h0);
    run_op(3'd1, 32'hCAFE_0000, 32'h8000_0000, 6'd32, 4'h0);   // R6 all ones
    run_op(3'd1, 32'hCAFE_0000, 32'h7FFF_FFFF, 6'd32, 4'h0);   // R6 all zeros
    run_op(3'd1, 32'hCAFE_0000, 32'h1234_5678, 6'd0, 4'h0);    // R8 zero shift
    run_op(3'd1, 32'hCAFE_0000, 32'h1234_5678, 6'd33, 4'h0);   // R8
    // R7 flag patterns
    run_op(3'd2, 32'hA1A2_A3A4, 32'hB1B2_B3B4, 6'd0, 4'hF);
    run_op(3'd2, 32'hA1A2_A3A4, 32'hB1B2_B3B4, 6'd0, 4'h0);
    run_op(3'd2, 32'hA1A2_A3A4, 32'hB1B2_B3B4, 6'd0, 4'h5);
    run_op(3'd2, 32'hA1A2_A3A4, 32'hB1B2_B3B4, 6'd0, 4'hA);
    // R9 shift has no effect on select
    sel_ref = model_res(3'd2, 32'h0F0F_F0F0, 32'h3C3C_C3C3, 6'd0, 4'h6);
    foreach (sel_ref[i]) if (i < 4) begin
      run_op(3'd2, 32'h0F0F_F0F0, 32'h3C3C_C3C3, 6'(i * 21), 4'h6);
      check("R9 shamt ignored", res, sel_ref);
    end
    // R10 undefined codes
    for (int o = 3; o < 8; o++) run_op(3'(o), 32'hDEAD_BEEF, 32'h1357_9BDF, 6'd4, 4'hF);

    // R2 idle: no strobe, result held
    run_op(3'd2, 32'h1111_1111, 32'h2222_2222, 6'd0, 4'h3);
    hold = res;
    op_a = 32'h5555_5555; op = 3'd2; ge_flags = 4'hF;
    repeat (2) @(negedge clk);
    check("R2 idle valid", {31'd0, res_valid}, 32'd0);
    check("R2 idle hold", res, hold);

    // constrained random, mostly legal shifts
    for (int n = 0; n < 400; n++) begin
      logic [2:0] ro;
      logic [5:0] rs;
      ro = ($urandom_range(0, 9) == 0) ? 3'($urandom_range(3, 7)) : 3'($urandom_range(0, 2));
      rs = ($urandom_range(0, 7) == 0) ? 6'($urandom) :
           (ro == 3'd1) ? 6'($urandom_range(1, 32)) : 6'($urandom_range(0, 31));
      run_op(ro, $urandom, $urandom, rs, 4'($urandom));
    end

    // R1 mid-run reset
    @(negedge clk);
    in_valid = 1'b1; op = 3'd2; ge_flags = 4'hF; op_a = 32'hFFFF_FFFF; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    check("R1 mid res", res, 32'h0);
    check("R1 mid valid", {31'd0, res_valid}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule